// File: doc/BRIEF.md
# Half-Buffer Interrupt Circular Buffer

This block is a ring of bytes shared between a link datapath that moves one byte per strobe and a processor that moves 32-bit words at its own pace. The link side walks a single pointer round the ring, storing incoming bytes on receive or fetching outgoing bytes on transmit. The processor reads or fills one half of the ring while the link works through the other half. One instance serves each direction.

When the link pointer steps past the last byte of the lower half, or past the last byte of the ring, an interrupt is raised together with a flag naming the half that has just been completed. The interrupt stays high until the processor acknowledges it. If the next boundary arrives while the interrupt is still pending, a sticky overrun flag records that service came too late. Capacity defaults to 4096 bytes and must be a power of two.

Top module: `halfbuf`

## Requirements
- R1: A synchronous reset sets `strm_ptr` to 0 and clears `irq`, `irq_half` and `overrun`.
- R2: `strm_ptr` increments by one on every cycle with `strm_valid` high, wrapping from DEPTH_BYTES-1 to 0, and holds otherwise.
- R3: A stream write stores `strm_wdata` at byte address `strm_ptr`; byte b lives in word b/4 at bits [8*(b mod 4) +: 8] (little-endian lanes).
- R4: A stream read (`strm_valid` high, `strm_we` low) presents the byte at `strm_ptr` on `strm_rdata` one cycle later; `strm_rdata` holds otherwise.
- R5: A processor read (`cpu_en` high, `cpu_we` low) presents word `cpu_addr` on `cpu_rdata` one cycle later, showing the contents from before any write in the same cycle.
- R6: A processor write (`cpu_en` and `cpu_we` high) replaces all four bytes of word `cpu_addr`.
- R7: A link access at byte DEPTH_BYTES/2-1 sets `irq` with `irq_half` = 0 on the next cycle.
- R8: A link access at byte DEPTH_BYTES-1 sets `irq` with `irq_half` = 1 on the next cycle.
- R9: `irq` stays high until a cycle with `irq_ack` high, and is low the cycle after such an acknowledge unless a boundary is reached in that same cycle, in which case it stays high without overrun.
- R10: Reaching a boundary while `irq` is high and `irq_ack` is low sets `overrun`, which then stays high until reset.
- R11: When the processor writes a word and the link writes a byte of that word in the same cycle, the link byte wins and the other three bytes take the processor data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strm_valid | input | 1 | Link byte access strobe; advances the pointer |
| strm_we | input | 1 | 1 = link writes a byte, 0 = link reads a byte |
| strm_wdata | input | 8 | Byte to store |
| strm_rdata | output | 8 | Byte fetched by the previous link read |
| strm_ptr | output | $clog2(DEPTH_BYTES) | Current link byte address |
| cpu_en | input | 1 | Processor word access strobe |
| cpu_we | input | 1 | 1 = processor writes, 0 = processor reads |
| cpu_addr | input | $clog2(DEPTH_BYTES)-2 | Processor word address |
| cpu_wdata | input | 32 | Word to store |
| cpu_rdata | output | 32 | Word fetched by the previous processor read |
| irq | output | 1 | Half-complete interrupt, held until acknowledged |
| irq_half | output | 1 | 0 = lower half done, 1 = upper half done |
| irq_ack | input | 1 | Interrupt acknowledge |
| overrun | output | 1 | Sticky: a boundary arrived while irq was pending |

## Verification
The bench builds the block with DEPTH_BYTES = 64, so the midpoint falls at byte 31 and the ring wraps after 64 strobes. That puts both interrupt boundaries, a full wrap, a late-service overrun and an acknowledge coinciding with a boundary within a few hundred cycles, while every byte lane of the word port still gets exercised through collisions and read-before-write cases.

// File: rtl/halfbuf.sv
module halfbuf #(
  parameter int DEPTH_BYTES = 4096
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            strm_valid,
  input  logic                            strm_we,
  input  logic [7:0]                      strm_wdata,
  output logic [7:0]                      strm_rdata,
  output logic [$clog2(DEPTH_BYTES)-1:0]  strm_ptr,
  input  logic                            cpu_en,
  input  logic                            cpu_we,
  input  logic [$clog2(DEPTH_BYTES)-3:0]  cpu_addr,
  input  logic [31:0]                     cpu_wdata,
  output logic [31:0]                     cpu_rdata,
  output logic                            irq,
  output logic                            irq_half,
  input  logic                            irq_ack,
  output logic                            overrun
);
  localparam int WORDS = DEPTH_BYTES / 4;
  localparam int AW    = $clog2(DEPTH_BYTES);
  localparam int WAW   = AW - 2;
  localparam logic [AW-1:0] MID  = AW'(DEPTH_BYTES / 2 - 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BYTES - 1);

  logic [31:0] mem [WORDS];

  logic [WAW-1:0] s_word;
  logic [4:0]     s_shift;
  logic           hit_mid, hit_end, boundary;

  assign s_word   = strm_ptr[AW-1:2];
  assign s_shift  = {strm_ptr[1:0], 3'b000};
  assign hit_mid  = strm_valid && (strm_ptr == MID);
  assign hit_end  = strm_valid && (strm_ptr == LAST);
  assign boundary = hit_mid || hit_end;

  always_ff @(posedge clk) begin
    if (cpu_en && cpu_we)
      mem[cpu_addr] <= cpu_wdata;
    if (strm_valid && strm_we)
      mem[s_word][s_shift +: 8] <= strm_wdata;
  end

  always_ff @(posedge clk) begin
    if (cpu_en && !cpu_we)
      cpu_rdata <= mem[cpu_addr];
    if (strm_valid && !strm_we)
      strm_rdata <= mem[s_word][s_shift +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strm_ptr <= '0;
      irq      <= 1'b0;
      irq_half <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (strm_valid)
        strm_ptr <= strm_ptr + 1'b1;
      if (boundary)
        irq <= 1'b1;
      else if (irq_ack)
        irq <= 1'b0;
      if (boundary)
        irq_half <= hit_end;
      if (boundary && irq && !irq_ack)
        overrun <= 1'b1;
    end
  end
endmodule

module halfbuf_chk #(
  parameter int DEPTH_BYTES = 4096
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           strm_valid,
  input logic [$clog2(DEPTH_BYTES)-1:0] strm_ptr,
  input logic                           irq,
  input logic                           irq_half,
  input logic                           irq_ack,
  input logic                           overrun
);
  localparam int AW = $clog2(DEPTH_BYTES);
  localparam logic [AW-1:0] MID  = AW'(DEPTH_BYTES / 2 - 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BYTES - 1);

  logic at_edge;
  assign at_edge = strm_valid && (strm_ptr == MID || strm_ptr == LAST);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !strm_valid |=> $stable(strm_ptr));
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (strm_valid && strm_ptr == LAST) |=> (strm_ptr == '0));
  a_r7_mid_irq: assert property (@(posedge clk) disable iff (rst)
    (strm_valid && strm_ptr == MID) |=> (irq && !irq_half));
  a_r8_end_irq: assert property (@(posedge clk) disable iff (rst)
    (strm_valid && strm_ptr == LAST) |=> (irq && irq_half));
  a_r9_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !at_edge) |=> !irq);
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  a_r10_late: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack && at_edge) |=> overrun);
endmodule

bind halfbuf halfbuf_chk #(.DEPTH_BYTES(DEPTH_BYTES)) u_chk (
  .clk(clk), .rst(rst), .strm_valid(strm_valid), .strm_ptr(strm_ptr),
  .irq(irq), .irq_half(irq_half), .irq_ack(irq_ack), .overrun(overrun)
);

// File: tb/tb_halfbuf.sv
module tb_halfbuf;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1;
  logic              sv = 0, swe = 0, ce = 0, cwe = 0, ack = 0;
  logic [7:0]        swd = '0;
  logic [AW-3:0]     cad = '0;
  logic [31:0]       cwd = '0;
  logic [7:0]        srd;
  logic [AW-1:0]     ptr;
  logic [31:0]       crd;
  logic              irq, ihalf, ovr;

  halfbuf #(.DEPTH_BYTES(DEPTH)) dut (
    .clk(clk), .rst(rst), .strm_valid(sv), .strm_we(swe), .strm_wdata(swd),
    .strm_rdata(srd), .strm_ptr(ptr), .cpu_en(ce), .cpu_we(cwe), .cpu_addr(cad),
    .cpu_wdata(cwd), .cpu_rdata(crd), .irq(irq), .irq_half(ihalf),
    .irq_ack(ack), .overrun(ovr)
  );

  int checks = 0, errors = 0;
  bit armed = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [7:0] mb [DEPTH];
  int   mptr = 0;
  bit   mirq = 0, mhalf = 0, movr = 0, s_seen = 0, c_seen = 0;
  logic [7:0]  m_srd;
  logic [31:0] m_crd;

  always @(posedge clk) begin
    if (ce && !cwe) begin
      m_crd = {mb[cad*4+3], mb[cad*4+2], mb[cad*4+1], mb[cad*4]};
      c_seen = 1;
    end
    if (sv && !swe) begin
      m_srd = mb[mptr];
      s_seen = 1;
    end
    if (rst) begin
      mptr = 0; mirq = 0; mhalf = 0; movr = 0;
    end else begin
      bit bnd;
      if (ce && cwe)
        for (int k = 0; k < 4; k++) mb[cad*4+k] = cwd[8*k +: 8];
      if (sv && swe) mb[mptr] = swd;
      bnd = sv && (mptr == DEPTH/2-1 || mptr == DEPTH-1);
      if (bnd && mirq && !ack) movr = 1;
      if (bnd) begin
        mhalf = (mptr == DEPTH-1);
        mirq = 1;
      end else if (ack) mirq = 0;
      if (sv) mptr = (mptr + 1) % DEPTH;
    end
  end

  always @(negedge clk) if (armed) begin
    chk(ptr == AW'(mptr), "R2 ptr", 32'(ptr), 32'(mptr));
    chk(irq == mirq, "R9 irq", 32'(irq), 32'(mirq));
    chk(ihalf == mhalf, "R8 irq_half", 32'(ihalf), 32'(mhalf));
    chk(ovr == movr, "R10 overrun", 32'(ovr), 32'(movr));
    if (s_seen) chk(srd === m_srd, "R4 strm_rdata", 32'(srd), 32'(m_srd));
    if (c_seen) chk(crd === m_crd, "R5 cpu_rdata", crd, m_crd);
  end

  task automatic cyc(input bit v, input bit we, input logic [7:0] d,
                     input bit e, input bit w, input int a, input logic [31:0] wd, input bit k);
    @(negedge clk); #1;
    sv = v; swe = we; swd = d; ce = e; cwe = w; cad = (AW-2)'(a); cwd = wd; ack = k;
  endtask
  task automatic idle(); cyc(0,0,0,0,0,0,0,0); endtask
  task automatic swr(input logic [7:0] d); cyc(1,1,d,0,0,0,0,0); endtask
  task automatic crdw(input int a); cyc(0,0,0,1,0,a,0,0); endtask
  task automatic do_reset();
    @(negedge clk); #1; rst = 1; sv = 0; ce = 0; ack = 0;
    repeat (2) @(negedge clk);
    #1 rst = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    armed = 1;
    @(negedge clk);
    chk(ptr == 0 && !irq && !ihalf && !ovr, "R1 reset state",
        {ptr, irq, ihalf, ovr}, 32'h0);

    for (int i = 0; i < 40; i++) swr(8'(i + 1));
    idle(); @(negedge clk);
    chk(irq && !ihalf, "R7 mid irq", {ihalf, irq}, 32'h1);
    chk(ptr == 40, "R2 ptr after 40", 32'(ptr), 32'd40);
    crdw(0); idle(); @(negedge clk);
    chk(crd == 32'h04030201, "R3 lane order", crd, 32'h04030201);
    crdw(9); idle(); @(negedge clk);
    chk(crd == 32'h28272625, "R3 word 9", crd, 32'h28272625);
    chk(irq, "R9 irq held without ack", 32'(irq), 32'h1);
    cyc(0,0,0,0,0,0,0,1); idle(); @(negedge clk);
    chk(!irq, "R9 ack clears", 32'(irq), 32'h0);

    for (int i = 40; i < 64; i++) swr(8'(i + 1));
    idle(); @(negedge clk);
    chk(irq && ihalf && ptr == 0, "R8 end irq and wrap", {ptr, ihalf, irq}, 32'h3);
    for (int i = 0; i < 32; i++) swr(8'(8'hA0 + i));
    idle(); @(negedge clk);
    chk(ovr, "R10 overrun set", 32'(ovr), 32'h1);
    cyc(0,0,0,0,0,0,0,1); idle(); idle(); @(negedge clk);
    chk(ovr && !irq, "R10 overrun sticky after ack", {irq, ovr}, 32'h1);

    do_reset();
    @(negedge clk);
    chk(ptr == 0 && !irq && !ovr && !ihalf, "R1 reset clears overrun",
        {ptr, irq, ihalf, ovr}, 32'h0);
    for (int i = 0; i < 63; i++) swr(8'(i));
    cyc(1,1,8'h3F,0,0,0,0,1);
    idle(); @(negedge clk);
    chk(irq && ihalf && !ovr, "R9 ack at boundary keeps irq",
        {ovr, ihalf, irq}, 32'h3);

    for (int w = 0; w < 16; w++) cyc(0,0,0,1,1,w,32'hC0DE0000 | 32'(w),0);
    crdw(5); idle(); @(negedge clk);
    chk(crd == 32'hC0DE0005, "R6 word write", crd, 32'hC0DE0005);
    cyc(1,0,0,0,0,0,0,0); cyc(1,0,0,0,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0); idle(); @(negedge clk);
    chk(srd == 8'hDE, "R4 stream read lane 2", 32'(srd), 32'hDE);
    cyc(1,0,0,0,0,0,0,0); idle(); @(negedge clk);
    chk(srd == 8'hC0 && ptr == 4, "R4 stream read lane 3", 32'(srd), 32'hC0);

    cyc(1,1,8'h5A,1,1,1,32'hFFFF_FFFF,0);
    crdw(1); idle(); @(negedge clk);
    chk(crd == 32'hFFFF_FF5A, "R11 stream byte wins", crd, 32'hFFFF_FF5A);
    cyc(1,1,8'h77,1,0,1,0,0); idle(); @(negedge clk);
    chk(crd == 32'hFFFF_FF5A, "R5 read before write", crd, 32'hFFFF_FF5A);
    crdw(1); idle(); @(negedge clk);
    chk(crd == 32'hFFFF_775A, "R3 later byte visible", crd, 32'hFFFF_775A);

    repeat (3) idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule